// File: doc/BRIEF.md
# Alarm Interrupt and Clock Output Controller

This block owns one multipurpose, active-low output pin of a real-time clock. In its default mode the pin is an alarm interrupt: when either of two alarm-match strobes fires and that alarm is enabled, the pin drops low for a fixed interval of about 20 ms. A mode bit picks between a single-event alarm and a recurring alarm. Independently of the enables, two sticky status flags record every alarm event. These flags stay set until a status read completes.

A two-bit select field can instead hand the pin to a free-running divider fed by the crystal oscillator. The divider can produce a 32.768 kHz, 4096 Hz or 1 Hz square wave. While a clock is selected, the interrupt function on the pin is off. The oscillator reaches the block as a one-cycle strobe at twice the crystal rate, one strobe per half period. This lets the fastest output be a true 50% square wave. Alarm time comparison, bus decoding and non-volatile storage sit outside.

Top module: `alarm_irq_clkout`

## Requirements
- R1: After reset the pin is high, both status flags read 0, both alarms are disabled, the mode is single-event and the pin is in interrupt mode.
- R2: An alarm-match strobe sets that alarm's status flag one cycle later, whether or not that alarm is enabled or a clock output is selected.
- R3: A status read-complete strobe clears both flags one cycle later.
- R4: A flag whose alarm strobe arrives in the same cycle as a read-complete strobe stays set. A flag is never cleared without a read-complete strobe.
- R5: In interrupt mode, an enabled alarm strobe drives the pin low in the next cycle. A strobe for a disabled alarm leaves the pin high.
- R6: The low pulse lasts exactly 1310 half-period strobes, which is 655 oscillator periods. A further alarm during the pulse neither extends it nor restarts it.
- R7: In single-event mode, only the first enabled alarm after a control write produces a pulse. Later alarms give none until the next control write.
- R8: In recurring mode, every enabled alarm that arrives while no pulse is active produces a new pulse.
- R9: Select value 01 gives 32.768 kHz. The pin equals bit 0 of the number of half-period strobes counted since reset, so it toggles on every strobe.
- R10: Select value 10 gives 4096 Hz and select value 11 gives 1 Hz. The pin equals bit 3 or bit 15, respectively, of the half-period strobe count since reset. Each output has a 50% duty cycle.
- R11: While the select field is non-zero, alarms produce no pulse. A pulse in progress is dropped. Returning the select field to 00 leaves the pin high.
- R12: Control word layout: bit 0 enables alarm 0, bit 1 enables alarm 1, bit 2 selects recurring mode, and bits 4:3 hold the output select. A write takes effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_half_tick | input | 1 | One-cycle strobe per half period of the 32.768 kHz crystal |
| alarm_hit | input | 2 | One-cycle alarm-match strobes, bit i for alarm i |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 5 | Control word (layout in R12) |
| status_rd_done | input | 1 | Strobe marking the end of a status read |
| irq_clk_n | output | 1 | Multipurpose pin: active-low interrupt or clock output |
| alarm_flags | output | 2 | Sticky alarm status flags |

## Verification
A flag register holding a wrong value shows on alarm_flags in the cycle after the strobe or read that should have changed it. A pulse counter or arming bit in a wrong state shows as a pin pulse that is too short, too long, extended, or missing. This only becomes visible when the pulse ends or when the next alarm arrives, up to 1310 strobes later. A corrupted divider shows on the pin within one strobe in 32.768 kHz mode. At the slower selections, the error may take up to half an output period to appear, because the pin is compared against a strobe count kept since reset.

// File: rtl/alrm_out_pkg.sv
package alrm_out_pkg;

    localparam int NUM_ALARMS = 2;

    typedef enum logic [1:0] {
        FS_IRQ  = 2'b00,
        FS_FAST = 2'b01,
        FS_MID  = 2'b10,
        FS_SLOW = 2'b11
    } fsel_e;

    typedef struct packed {
        fsel_e                 fsel;
        logic                  rep;
        logic [NUM_ALARMS-1:0] en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/alm_status_flags.sv
module alm_status_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    input  logic         rd_done,
    output logic [N-1:0] flags
);

    typedef struct packed {
        logic [N-1:0] flags;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (rd_done) begin
                st_d.flags[i] = 1'b0;
            end
            if (hit[i]) begin
                st_d.flags[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;

    for (genvar g = 0; g < N; g++) begin : g_chk
        p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> flags[g]);
        p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_done && !hit[g]) |=> !flags[g]);
        p_flag_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_done && flags[g]) |=> flags[g]);
    end

endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen #(
    parameter int PULSE_PERIODS = 655
) (
    input  logic clk,
    input  logic rst_n,
    input  logic half_tick,
    input  logic trig,
    input  logic allow,
    input  logic rep_mode,
    input  logic rearm,
    output logic active_nxt
);

    localparam int PULSE_HT = 2 * PULSE_PERIODS;
    localparam int CW       = $clog2(PULSE_HT);
    localparam logic [CW-1:0] LAST = CW'(PULSE_HT - 1);

    typedef struct packed {
        logic          active;
        logic          armed;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!allow) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (half_tick) begin
                if (st_q.cnt == LAST) begin
                    st_d.active = 1'b0;
                    st_d.cnt    = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end else if (trig && (rep_mode || st_q.armed)) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.armed  = 1'b0;
        end
        if (rearm) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, armed: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_nxt = st_d.active;

    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.cnt <= LAST));
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |-> (st_q.cnt == '0));
    p_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !allow |=> !st_q.active);
    p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && !rep_mode && !rearm && !st_q.active) |=> !st_q.active);
    p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && allow && trig && rep_mode) |=> st_q.active);

endmodule

// File: rtl/clk_half_divider.sv
module clk_half_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         half_tick,
    output logic [W-1:0] cnt_nxt
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (half_tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_nxt = st_d.cnt;

    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));
    p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !half_tick |=> $stable(st_q.cnt));

endmodule

// File: rtl/alarm_irq_clkout.sv
module alarm_irq_clkout
    import alrm_out_pkg::*;
#(
    parameter int OSC_HZ        = 32768,
    parameter int MID_HZ        = 4096,
    parameter int SLOW_HZ       = 1,
    parameter int PULSE_PERIODS = 655
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  osc_half_tick,
    input  logic [NUM_ALARMS-1:0] alarm_hit,
    input  logic                  ctrl_we,
    input  logic [CTRL_W-1:0]     ctrl_wdata,
    input  logic                  status_rd_done,
    output logic                  irq_clk_n,
    output logic [NUM_ALARMS-1:0] alarm_flags
);

    localparam int B_FAST = 0;
    localparam int B_MID  = $clog2(OSC_HZ / MID_HZ);
    localparam int B_SLOW = $clog2(OSC_HZ / SLOW_HZ);
    localparam int DIV_W  = B_SLOW + 1;

    typedef struct packed {
        ctrl_t ctrl;
        logic  pin;
    } st_t;

    st_t              st_d, st_q;
    logic             trig;
    logic             allow;
    logic             active_nxt;
    logic [DIV_W-1:0] div_nxt;

    alm_status_flags #(
        .N (NUM_ALARMS)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (alarm_hit),
        .rd_done (status_rd_done),
        .flags   (alarm_flags)
    );

    irq_pulse_gen #(
        .PULSE_PERIODS (PULSE_PERIODS)
    ) u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_tick  (osc_half_tick),
        .trig       (trig),
        .allow      (allow),
        .rep_mode   (st_q.ctrl.rep),
        .rearm      (ctrl_we),
        .active_nxt (active_nxt)
    );

    clk_half_divider #(
        .W (DIV_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (osc_half_tick),
        .cnt_nxt   (div_nxt)
    );

    always_comb begin
        trig  = |(alarm_hit & st_q.ctrl.en);
        allow = (st_q.ctrl.fsel == FS_IRQ);
    end

    always_comb begin
        st_d = st_q;
        if (ctrl_we) begin
            st_d.ctrl = ctrl_t'(ctrl_wdata);
        end
        case (st_d.ctrl.fsel)
            FS_IRQ:  st_d.pin = !active_nxt;
            FS_FAST: st_d.pin = div_nxt[B_FAST];
            FS_MID:  st_d.pin = div_nxt[B_MID];
            FS_SLOW: st_d.pin = div_nxt[B_SLOW];
            default: st_d.pin = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ctrl: '{fsel: FS_IRQ, rep: 1'b0, en: '0}, pin: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_clk_n = st_q.pin;

    p_fast_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.fsel == FS_FAST && !ctrl_we && osc_half_tick)
        |=> (irq_clk_n != $past(irq_clk_n)));
    p_clock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.fsel != FS_IRQ && !ctrl_we && !osc_half_tick)
        |=> $stable(irq_clk_n));
    p_back_to_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.fsel != FS_IRQ && ctrl_we && ctrl_wdata[4:3] == 2'b00)
        |=> irq_clk_n);

endmodule

// File: tb/tb_alarm_irq_clkout.sv
module tb_alarm_irq_clkout;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_half_tick = 1'b0;
    logic [1:0] alarm_hit = 2'b00;
    logic       ctrl_we = 1'b0;
    logic [4:0] ctrl_wdata = 5'd0;
    logic       status_rd_done = 1'b0;
    logic       irq_clk_n;
    logic [1:0] alarm_flags;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int tick_every = 0;
    int tick_ph = 0;
    int tick_seen = 0;

    always #10 clk = ~clk;

    alarm_irq_clkout dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .osc_half_tick  (osc_half_tick),
        .alarm_hit      (alarm_hit),
        .ctrl_we        (ctrl_we),
        .ctrl_wdata     (ctrl_wdata),
        .status_rd_done (status_rd_done),
        .irq_clk_n      (irq_clk_n),
        .alarm_flags    (alarm_flags)
    );

    always @(negedge clk) begin
        if (!rst_n || tick_every == 0) begin
            osc_half_tick <= 1'b0;
            tick_ph <= 0;
        end else if (tick_ph + 1 >= tick_every) begin
            osc_half_tick <= 1'b1;
            tick_ph <= 0;
        end else begin
            osc_half_tick <= 1'b0;
            tick_ph <= tick_ph + 1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) tick_seen <= 0;
        else if (osc_half_tick) tick_seen <= tick_seen + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // control word: [0] en0, [1] en1, [2] recurring, [4:3] select (R12)
    task automatic wr_ctrl(input logic [1:0] sel, input logic rep, input logic [1:0] en);
        ctrl_we = 1'b1;
        ctrl_wdata = {sel, rep, en};
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic strobe(input logic [1:0] hit, input logic rd);
        alarm_hit = hit;
        status_rd_done = rd;
        @(negedge clk);
        alarm_hit = 2'b00;
        status_rd_done = 1'b0;
    endtask

    task automatic count_low(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            if (irq_clk_n == 1'b0) lows++;
            @(negedge clk);
        end
    endtask

    task automatic measure_pulse(input int inject_at, input logic [1:0] mask, output int ticks);
        int t0;
        int n;
        t0 = tick_seen;
        n = 0;
        while (irq_clk_n == 1'b0 && n < 20000) begin
            if (n == inject_at) alarm_hit = mask;
            @(negedge clk);
            alarm_hit = 2'b00;
            n++;
        end
        ticks = tick_seen - t0;
    endtask

    task automatic t_reset();
        chk("R1 pin after reset", int'(irq_clk_n), 1);
        chk("R1 flags after reset", int'(alarm_flags), 0);
    endtask

    task automatic t_flags();
        int lows;
        strobe(2'b01, 1'b0);
        chk("R2 flag0 set while disabled", int'(alarm_flags), 1);
        count_low(10, lows);
        chk("R5 disabled alarm no pulse", lows, 0);
        strobe(2'b10, 1'b0);
        chk("R2 flag1 set", int'(alarm_flags), 3);
        repeat (5) @(negedge clk);
        chk("R4 flags hold without read", int'(alarm_flags), 3);
        strobe(2'b00, 1'b1);
        chk("R3 read clears flags", int'(alarm_flags), 0);
        strobe(2'b01, 1'b0);
        strobe(2'b01, 1'b1);
        chk("R4 hit with read keeps flag", int'(alarm_flags), 1);
        strobe(2'b10, 1'b1);
        chk("R4 other flag cleared, hit flag kept", int'(alarm_flags), 2);
        strobe(2'b00, 1'b1);
        chk("R3 read clears", int'(alarm_flags), 0);
    endtask

    task automatic t_oneshot();
        int lows;
        int ticks;
        tick_every = 1;
        wr_ctrl(2'b00, 1'b0, 2'b01);
        strobe(2'b10, 1'b0);
        count_low(10, lows);
        chk("R12 alarm1 disabled by bit1=0", lows, 0);
        strobe(2'b01, 1'b0);
        chk("R5 pin low next cycle", int'(irq_clk_n), 0);
        measure_pulse(-1, 2'b00, ticks);
        chk("R6 pulse width dense ticks", ticks, 1310);
        strobe(2'b01, 1'b0);
        count_low(20, lows);
        chk("R7 second alarm no pulse", lows, 0);
        wr_ctrl(2'b00, 1'b0, 2'b01);
        strobe(2'b01, 1'b0);
        chk("R7 rearmed by write", int'(irq_clk_n), 0);
        measure_pulse(-1, 2'b00, ticks);
        chk("R6 rearmed pulse width", ticks, 1310);
        strobe(2'b00, 1'b1);
    endtask

    task automatic t_repeat();
        int ticks;
        tick_every = 3;
        wr_ctrl(2'b00, 1'b1, 2'b10);
        strobe(2'b10, 1'b0);
        chk("R12 alarm1 enabled by bit1", int'(irq_clk_n), 0);
        measure_pulse(100, 2'b10, ticks);
        chk("R6 no extension, sparse ticks", ticks, 1310);
        strobe(2'b10, 1'b0);
        chk("R8 recurring second pulse", int'(irq_clk_n), 0);
        measure_pulse(-1, 2'b00, ticks);
        chk("R8 recurring pulse width", ticks, 1310);
        strobe(2'b10, 1'b0);
        chk("R8 recurring third pulse", int'(irq_clk_n), 0);
        strobe(2'b00, 1'b1);
    endtask

    task automatic t_clock();
        int bad;
        int toggles;
        logic prev;
        tick_every = 2;
        wr_ctrl(2'b01, 1'b0, 2'b11);
        bad = 0;
        for (int i = 0; i < 200; i++) begin
            if (irq_clk_n != tick_seen[0]) bad++;
            @(negedge clk);
        end
        chk("R9 fast clock tracks strobe count bit0", bad, 0);
        wr_ctrl(2'b10, 1'b0, 2'b11);
        bad = 0;
        for (int i = 0; i < 300; i++) begin
            if (i == 50) alarm_hit = 2'b11;
            if (irq_clk_n != tick_seen[3]) bad++;
            @(negedge clk);
            alarm_hit = 2'b00;
        end
        chk("R10 mid clock tracks bit3", bad, 0);
        chk("R11 R2 flags set in clock mode", int'(alarm_flags), 3);
        wr_ctrl(2'b00, 1'b0, 2'b11);
        chk("R11 pin high back in irq mode", int'(irq_clk_n), 1);
        strobe(2'b00, 1'b1);
        // pulse in progress dropped by switching to clock output
        strobe(2'b01, 1'b0);
        chk("R5 pulse started", int'(irq_clk_n), 0);
        wr_ctrl(2'b01, 1'b0, 2'b11);
        wr_ctrl(2'b00, 1'b0, 2'b11);
        chk("R11 pulse dropped by clock select", int'(irq_clk_n), 1);
        tick_every = 1;
        wr_ctrl(2'b11, 1'b0, 2'b00);
        bad = 0;
        toggles = 0;
        prev = irq_clk_n;
        for (int i = 0; i < 66000; i++) begin
            if (irq_clk_n != tick_seen[15]) bad++;
            if (irq_clk_n != prev) toggles++;
            prev = irq_clk_n;
            @(negedge clk);
        end
        chk("R10 slow clock tracks bit15", bad, 0);
        chk("R10 slow clock toggles twice", toggles, 2);
        strobe(2'b00, 1'b1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flags();
        t_oneshot();
        t_repeat();
        t_clock();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule